// File: doc/BRIEF.md
# Converter result parallel output port

This block is the digital read side of a sampling converter. A conversion engine signals the start of each conversion, holds a busy flag while it runs, and pulses a result strobe with an 18-bit result when it finishes. The block keeps the last accepted result in a register. It presents that result on an 18-lane data bus, and each lane has its own output enable so that a high-impedance state can be modelled.

The host selects the bus width per access: all 18 lanes, a 16-lane word, or an 8-lane byte. In the narrow modes, a swap control picks which byte of the upper 16 result bits appears on the low lanes. A coding control chooses straight binary or two's complement for the narrow modes. Because the register changes only when a finished result arrives, a read made during a conversion returns the previous result. A host that holds the bus enabled all the time sees the new value as soon as the conversion ends.

Top module: `parallel_result_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stored result is cleared to zero by that edge. While `rst_n` is low, every bit of `bus_oe` and `bus_q` is 0.
- R2: When `sel_n` or `rd_n` is high, every bit of `bus_oe` and `bus_q` is 0. Lanes are driven only when both are low. A lane whose enable is 0 always shows 0 on `bus_q`.
- R3: A `conv_start` pulse seen at a clock edge while `busy` is low arms the port to accept one result. A `conv_start` seen while `busy` is high is ignored.
- R4: The result register loads `res_data` at an edge where `res_valid` is high, `busy` is low and the port is armed, and loading disarms the port. A strobe with no arming start, a strobe while `busy` is high, and a second strobe after one start all leave the stored result unchanged.
- R5: A read made while a conversion is running (`busy` high) returns the result of the previous conversion.
- R6: With `sel_n` and `rd_n` held low, the bus keeps the previous value up to the accepting strobe edge. From the cycle after that edge it shows the new result.
- R7: With `width_sel` = 2'b00 (full), all 18 lanes are driven with the stored result in straight binary, whatever the value of `coding`.
- R8: With `width_sel` = 2'b01 (word), lanes 15:0 carry result bits 17:2 and lanes 17:16 are not driven. With `swap` = 1, lanes 15:8 carry result bits 9:2 and lanes 7:0 carry result bits 17:10.
- R9: With `width_sel` = 2'b10 or 2'b11 (byte), only lanes 7:0 are driven. They carry result bits 17:10 when `swap` = 0 and result bits 9:2 when `swap` = 1.
- R10: With `coding` = 1 in word or byte mode, result bit 17 is inverted before the lanes are selected (two's complement). With `coding` = 0 the bits pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| conv_start | input | 1 | Conversion start pulse from the host |
| busy | input | 1 | Conversion-in-progress flag from the engine |
| res_valid | input | 1 | Finished-result strobe from the engine |
| res_data | input | 18 | Result from the engine, straight binary |
| swap | input | 1 | Byte order select for the word and byte modes |
| coding | input | 1 | 1 = two's complement, 0 = straight binary |
| width_sel | input | 2 | 00 full, 01 word, 10/11 byte |
| bus_q | output | 18 | Bus lane values |
| bus_oe | output | 18 | Per-lane output enable |

## Verification
The bench builds the port with its default parameters: an 18-bit result and 8-bit bytes. With these values the word lanes and byte lanes sit at fixed positions that the bench can check against its own model. Every combination of width, swap and coding is tried on several patterns, including a value that has only bit 17 set, so that the inverted sign bit clears a whole word. The arming rules are tested with stray strobes, a start pulse during busy and double strobes, and the read-during-conversion and continuous-read timings are checked at the exact edge where the strobe is taken.

// File: rtl/rpo_pkg.sv
// Package: shared types for the parallel result port.
// Assumes the bus width code is two bits wide; both byte codes mean the same mode.
package rpo_pkg;

    typedef enum logic [1:0] {
        BW_FULL     = 2'b00,
        BW_WORD     = 2'b01,
        BW_BYTE     = 2'b10,
        BW_BYTE_ALT = 2'b11
    } bus_width_e;

endpackage

// File: rtl/rpo_result_reg.sv
// Result holding register. Stores one finished conversion result.
// Assumes the engine raises res_valid in the cycle busy is already low.
// One conv_start (taken while idle) permits exactly one load.
module rpo_result_reg #(
    parameter int RES_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             busy,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    output logic [RES_W-1:0] result_q
);

    logic armed_q;
    logic take;
    logic arm;

    // Purpose: decide whether this edge loads a result or arms for one.
    always_comb begin
        take = res_valid && !busy && armed_q;
        arm  = conv_start && !busy;
    end

    // Purpose: track the one-shot permission to accept a result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (arm) begin
            armed_q <= 1'b1;
        end else if (take) begin
            armed_q <= 1'b0;
        end
    end

    // Purpose: capture the result only on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (take) begin
            result_q <= res_data;
        end
    end

endmodule

// File: rtl/rpo_coder.sv
// Output coder. In the narrow modes it can turn the straight-binary result
// into two's complement by flipping the top bit. Full mode is always straight binary.
module rpo_coder #(
    parameter int RES_W = 18
) (
    input  logic [RES_W-1:0] result,
    input  logic             twos,
    input  logic             full_mode,
    output logic [RES_W-1:0] coded
);

    // Purpose: flip the sign bit when two's complement applies.
    always_comb begin
        coded            = result;
        coded[RES_W-1]   = result[RES_W-1] ^ (twos && !full_mode);
    end

endmodule

// File: rtl/rpo_lane_mux.sv
// Lane multiplexer. Places the coded result on the lanes for the chosen
// width and byte order, and marks which lanes carry data.
// Assumes RES_W >= 2*BYTE_W; the word is the upper 2*BYTE_W result bits.
module rpo_lane_mux
    import rpo_pkg::*;
#(
    parameter int RES_W  = 18,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0] coded,
    input  bus_width_e       mode,
    input  logic             swap,
    output logic [RES_W-1:0] lane_data,
    output logic [RES_W-1:0] lane_en
);

    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] word;
    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] lo_byte;

    // Purpose: split the upper result bits into the two bytes.
    always_comb begin
        word    = coded[RES_W-1 -: WORD_W];
        hi_byte = word[WORD_W-1 -: BYTE_W];
        lo_byte = word[BYTE_W-1:0];
    end

    // Purpose: route bytes to lanes and flag the lanes in use.
    always_comb begin
        lane_data = '0;
        lane_en   = '0;
        case (mode)
            BW_FULL: begin
                lane_data = coded;
                lane_en   = '1;
            end
            BW_WORD: begin
                lane_data[WORD_W-1:0] = swap ? {lo_byte, hi_byte} : {hi_byte, lo_byte};
                lane_en[WORD_W-1:0]   = '1;
            end
            default: begin
                lane_data[BYTE_W-1:0] = swap ? lo_byte : hi_byte;
                lane_en[BYTE_W-1:0]   = '1;
            end
        endcase
    end

endmodule

// File: rtl/rpo_bus_gate.sv
// Bus gate. Enables each lane only when the port is selected and read,
// and out of reset. A disabled lane outputs 0 next to a 0 enable.
module rpo_bus_gate #(
    parameter int RES_W = 18
) (
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             rd_n,
    input  logic [RES_W-1:0] lane_data,
    input  logic [RES_W-1:0] lane_en,
    output logic [RES_W-1:0] bus_q,
    output logic [RES_W-1:0] bus_oe
);

    logic drive;

    // Purpose: the bus is open only for a selected read outside reset.
    always_comb drive = rst_n && !sel_n && !rd_n;

    for (genvar i = 0; i < RES_W; i++) begin : g_lane
        assign bus_oe[i] = drive && lane_en[i];
        assign bus_q[i]  = drive && lane_en[i] && lane_data[i];
    end

endmodule

// File: rtl/parallel_result_port.sv
// Top level of the converter result parallel output port.
// Holds the last accepted result and presents it on a lane bus of
// selectable width, byte order and coding, with per-lane enables.
// Assumes all inputs are synchronous to clk.
module parallel_result_port
    import rpo_pkg::*;
#(
    parameter int RES_W  = 18,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             rd_n,
    input  logic             conv_start,
    input  logic             busy,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic             swap,
    input  logic             coding,
    input  logic [1:0]       width_sel,
    output logic [RES_W-1:0] bus_q,
    output logic [RES_W-1:0] bus_oe
);

    logic [RES_W-1:0] result_q;
    logic [RES_W-1:0] coded;
    logic [RES_W-1:0] lane_data;
    logic [RES_W-1:0] lane_en;
    bus_width_e       mode;
    logic             full_mode;

    // Purpose: decode the width code into the mode type.
    always_comb begin
        mode      = bus_width_e'(width_sel);
        full_mode = (mode == BW_FULL);
    end

    rpo_result_reg #(.RES_W(RES_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .busy       (busy),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .result_q   (result_q)
    );

    rpo_coder #(.RES_W(RES_W)) u_coder (
        .result    (result_q),
        .twos      (coding),
        .full_mode (full_mode),
        .coded     (coded)
    );

    rpo_lane_mux #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_mux (
        .coded     (coded),
        .mode      (mode),
        .swap      (swap),
        .lane_data (lane_data),
        .lane_en   (lane_en)
    );

    rpo_bus_gate #(.RES_W(RES_W)) u_gate (
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .rd_n      (rd_n),
        .lane_data (lane_data),
        .lane_en   (lane_en),
        .bus_q     (bus_q),
        .bus_oe    (bus_oe)
    );

endmodule

// File: rtl/rpo_checker.sv
// Property checker for the parallel result port, bound to the top module.
module rpo_checker #(
    parameter int RES_W  = 18,
    parameter int BYTE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_n,
    input logic             rd_n,
    input logic             busy,
    input logic             res_valid,
    input logic [1:0]       width_sel,
    input logic [RES_W-1:0] result_q,
    input logic [RES_W-1:0] bus_q,
    input logic [RES_W-1:0] bus_oe
);

    localparam int WORD_W = 2 * BYTE_W;
    localparam logic [RES_W-1:0] WORD_MASK = RES_W'((1 << WORD_W) - 1);
    localparam logic [RES_W-1:0] BYTE_MASK = RES_W'((1 << BYTE_W) - 1);

    logic reading;
    always_comb reading = !sel_n && !rd_n;

    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> (result_q == '0));

    p_reset_hiz_r1: assert property (@(posedge clk) !rst_n |-> (bus_oe == '0));

    p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n || rd_n) |-> (bus_oe == '0 && bus_q == '0));

    p_hold_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(result_q));

    p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(result_q));

    p_full_plain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && width_sel == 2'b00) |-> (bus_q == result_q && bus_oe == '1));

    p_word_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && width_sel == 2'b01) |-> (bus_oe == WORD_MASK));

    p_byte_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && width_sel[1]) |-> (bus_oe == BYTE_MASK));

endmodule

bind parallel_result_port rpo_checker #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n     (sel_n),
    .rd_n      (rd_n),
    .busy      (busy),
    .res_valid (res_valid),
    .width_sel (width_sel),
    .result_q  (result_q),
    .bus_q     (bus_q),
    .bus_oe    (bus_oe)
);

// File: tb/tb_parallel_result_port.sv
module tb_parallel_result_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        conv_start = 1'b0;
    logic        busy = 1'b0;
    logic        res_valid = 1'b0;
    logic [17:0] res_data = '0;
    logic        swap = 1'b0;
    logic        coding = 1'b0;
    logic [1:0]  width_sel = 2'b00;
    logic [17:0] bus_q;
    logic [17:0] bus_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    parallel_result_port dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_n(rd_n),
        .conv_start(conv_start), .busy(busy), .res_valid(res_valid),
        .res_data(res_data), .swap(swap), .coding(coding),
        .width_sel(width_sel), .bus_q(bus_q), .bus_oe(bus_oe)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected {oe, q} from the requirements R2, R7-R10 for an enabled read.
    function automatic logic [35:0] model(input logic [17:0] r, input logic [1:0] w,
                                          input logic sw, input logic tc);
        logic [17:0] c;
        logic [15:0] wd;
        logic [7:0]  hi;
        logic [7:0]  lo;
        c = r;
        if (tc && w != 2'b00) c[17] = ~c[17];
        wd = c[17:2];
        hi = wd[15:8];
        lo = wd[7:0];
        case (w)
            2'b00:   return {18'h3FFFF, c};
            2'b01:   return {18'h0FFFF, 2'b00, (sw ? {lo, hi} : {hi, lo})};
            default: return {18'h000FF, 10'b0, (sw ? lo : hi)};
        endcase
    endfunction

    // One full conversion: start, busy window, accepting strobe.
    task automatic convert(input logic [17:0] val, input int nbusy);
        conv_start = 1'b1; busy = 1'b0; tick();
        conv_start = 1'b0; busy = 1'b1;
        repeat (nbusy) tick();
        busy = 1'b0; res_valid = 1'b1; res_data = val; tick();
        res_valid = 1'b0; res_data = 18'h15555;
    endtask

    task automatic read_full(output logic [17:0] v);
        sel_n = 1'b0; rd_n = 1'b0; width_sel = 2'b00; #1;
        v = bus_q;
    endtask

    task automatic t_reset();
        sel_n = 1'b0; rd_n = 1'b0; rst_n = 1'b0;
        tick(); tick();
        chk("R1 oe in reset", bus_oe, '0);
        chk("R1 q in reset", bus_q, '0);
        rst_n = 1'b1; tick();
        chk("R1 cleared result", bus_q, '0);
        chk("R1 full lanes after reset", bus_oe, 18'h3FFFF);
    endtask

    task automatic t_hiz();
        convert(18'h2A5C3, 3);
        sel_n = 1'b1; rd_n = 1'b0; width_sel = 2'b00; #1;
        chk("R2 sel high oe", bus_oe, '0);
        chk("R2 sel high q", bus_q, '0);
        sel_n = 1'b0; rd_n = 1'b1; #1;
        chk("R2 rd high oe", bus_oe, '0);
        sel_n = 1'b1; #1;
        chk("R2 both high q", bus_q, '0);
        sel_n = 1'b0; rd_n = 1'b0; #1;
        chk("R2 both low drives", bus_q, 18'h2A5C3);
    endtask

    task automatic t_modes(input logic [17:0] val);
        logic [35:0] e;
        convert(val, 2);
        sel_n = 1'b0; rd_n = 1'b0;
        for (int w = 0; w < 4; w++) begin
            for (int s = 0; s < 2; s++) begin
                for (int t = 0; t < 2; t++) begin
                    width_sel = w[1:0]; swap = s[0]; coding = t[0]; #1;
                    e = model(val, w[1:0], s[0], t[0]);
                    if (w == 0) begin
                        chk("R7 full data", bus_q, e[17:0]);
                        chk("R7 full lanes", bus_oe, e[35:18]);
                    end else if (w == 1) begin
                        chk("R8/R10 word data", bus_q, e[17:0]);
                        chk("R8 word lanes", bus_oe, e[35:18]);
                    end else begin
                        chk("R9/R10 byte data", bus_q, e[17:0]);
                        chk("R9 byte lanes", bus_oe, e[35:18]);
                    end
                end
            end
        end
        swap = 1'b0; coding = 1'b0; width_sel = 2'b00;
    endtask

    task automatic t_coding_explicit();
        convert(18'h20000, 1);
        sel_n = 1'b0; rd_n = 1'b0; width_sel = 2'b01; swap = 1'b0; coding = 1'b1; #1;
        chk("R10 sign flip clears word", bus_q, 18'h00000);
        coding = 1'b0; #1;
        chk("R10 plain word", bus_q, 18'h08000);
        width_sel = 2'b00; coding = 1'b1; #1;
        chk("R7 coding ignored in full", bus_q, 18'h20000);
        width_sel = 2'b10; swap = 1'b0; #1;
        chk("R9 byte high signed", bus_q, 18'h00000);
        coding = 1'b0; width_sel = 2'b00;
    endtask

    task automatic t_read_during();
        logic [17:0] v;
        convert(18'h1F00F, 2);
        conv_start = 1'b1; tick(); conv_start = 1'b0; busy = 1'b1;
        tick();
        read_full(v);
        chk("R5 read during busy gives previous", v, 18'h1F00F);
        res_valid = 1'b1; res_data = 18'h0ABCD; tick(); res_valid = 1'b0;
        read_full(v);
        chk("R4 strobe while busy ignored", v, 18'h1F00F);
        busy = 1'b0; res_valid = 1'b1; res_data = 18'h0ABCD; tick(); res_valid = 1'b0;
        read_full(v);
        chk("R5 after busy falls new result", v, 18'h0ABCD);
    endtask

    task automatic t_continuous();
        sel_n = 1'b0; rd_n = 1'b0; width_sel = 2'b00;
        convert(18'h11111, 1);
        conv_start = 1'b1; tick(); conv_start = 1'b0; busy = 1'b1;
        tick(); tick();
        chk("R6 previous during conversion", bus_q, 18'h11111);
        busy = 1'b0; res_valid = 1'b1; res_data = 18'h3C3C3; #1;
        chk("R6 old value at strobe cycle", bus_q, 18'h11111);
        tick(); res_valid = 1'b0;
        chk("R6 new value after strobe edge", bus_q, 18'h3C3C3);
    endtask

    task automatic t_arming();
        logic [17:0] v;
        convert(18'h00777, 1);
        res_valid = 1'b1; res_data = 18'h12345; tick(); res_valid = 1'b0;
        read_full(v);
        chk("R4 second strobe ignored", v, 18'h00777);
        busy = 1'b1; conv_start = 1'b1; tick(); conv_start = 1'b0; busy = 1'b0;
        res_valid = 1'b1; res_data = 18'h2BEEF; tick(); res_valid = 1'b0;
        read_full(v);
        chk("R3 start during busy ignored", v, 18'h00777);
        conv_start = 1'b1; tick(); conv_start = 1'b0; tick(); tick();
        res_valid = 1'b1; res_data = 18'h2BEEF; tick(); res_valid = 1'b0;
        read_full(v);
        chk("R3 idle start arms", v, 18'h2BEEF);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_hiz();
        t_modes(18'h2A5C3);
        t_modes(18'h3FFFF);
        t_modes(18'h1D2B4);
        t_coding_explicit();
        t_read_during();
        t_continuous();
        t_arming();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule